// File: doc/BRIEF.md
# Binary-Tree Identifier Mapping Walker

This block translates a 12-bit peripheral identifier (the key) into an 8-bit slot number. It does this by walking a decision tree held in an internal node table. Each node names one bit of the key to test. The value of that bit picks one of two outcomes in the node. An outcome either points to another node or ends the walk with a slot number. A slot that is found is then checked against a per-slot ownership table. If the owner does not match the configured owner, the lookup reports a miss.

A client presents a key while the walker is idle. It then waits for a one-cycle response carrying the slot and a hit flag. A miss always returns the out-of-range value 256. Software or a loader fills the node table and the ownership table through a single write port. A write that arrives during a walk is parked in a one-entry holding register and applied once the walker is idle, so a walk always sees one consistent table.

Top module: `tree_id_mapper`

## Requirements
- R1: After reset, `req_ready` and `wr_ready` are 1 and `rsp_valid` is 0.
- R2: Node bits 21:18 give the number of the key bit to test. The key is zero-extended to 16 bits, so key bits 12 to 15 always test as 0.
- R3: When the tested bit is 0, the outcome is node bit 17 (continue flag) and bits 16:9 (value). When the tested bit is 1, the outcome is bit 8 (continue flag) and bits 7:0 (value).
- R4: Every walk starts at node 0. If the chosen continue flag is 1, the value is the next node index. If it is 0, the value is the final slot and the walk ends.
- R5: The walker visits one node per cycle. For a request accepted at clock edge k, a walk of n nodes raises `rsp_valid` for exactly one cycle after edge k+n. `req_ready` is 0 from edge k until that response.
- R6: A walk that would continue past its 16th visited node ends with `rsp_slot` = 256 and `rsp_hit` = 0. This response comes after 16 visits.
- R7: Continuing to a node index of 255 or more (outside the 255-node table) ends the walk with `rsp_slot` = 256 and `rsp_hit` = 0.
- R8: A final slot whose ownership entry (low 3 bits written with `wr_is_owner` = 1) differs from `cfg_owner` gives `rsp_slot` = 256 and `rsp_hit` = 0. A matching entry gives the slot with `rsp_hit` = 1.
- R9: A write is accepted while `wr_ready` is 1. It is applied on the first clock edge at which the walker is idle, and never during a walk. `wr_ready` stays 0 while a write is parked.
- R10: `req_valid` is ignored while `req_ready` is 0. No second walk and no extra response result from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request |
| req_key | input | 12 | Identifier to translate |
| req_ready | output | 1 | Walker idle; a request is taken this cycle |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_slot | output | 9 | Slot number, or 256 on miss |
| rsp_hit | output | 1 | 1 when the slot was found and owned |
| cfg_owner | input | 3 | Owner the found slot must match |
| wr_en | input | 1 | Table write strobe |
| wr_is_owner | input | 1 | 0: node table write, 1: ownership table write |
| wr_addr | input | 8 | Node index or slot number to write |
| wr_data | input | 32 | Node word, or owner in bits 2:0 |
| wr_ready | output | 1 | Write holding register empty |

## Verification
Keys are chosen to steer the walk down both outcomes of each node: short two-node paths, three-node paths, and a node that tests a bit above the key width. This separates a wrong bit select from a swapped outcome field. Each lookup also measures latency, which exposes an extra or missing pipeline stage. A self-looping node exercises the depth limit, and a pointer to index 255 exercises the out-of-table miss. An ownership mismatch shows whether the owner check is applied. A node rewritten in the middle of a long walk shows whether writes are held back. A request raised while busy shows whether it is dropped.

// File: rtl/tidm_pkg.sv
package tidm_pkg;
    parameter int KEY_W_DEF     = 12;
    parameter int SLOT_W_DEF    = 8;
    parameter int NODES_DEF     = 255;
    parameter int NODE_W_DEF    = 32;
    parameter int MAX_DEPTH_DEF = 16;
    parameter int OWN_W_DEF     = 3;
    parameter int SEL_W         = 4;

    typedef enum logic {
        W_IDLE = 1'b0,
        W_RUN  = 1'b1
    } walk_state_e;
endpackage

// File: rtl/tidm_store.sv
module tidm_store #(
    parameter int SLOT_W = tidm_pkg::SLOT_W_DEF,
    parameter int NODES  = tidm_pkg::NODES_DEF,
    parameter int NODE_W = tidm_pkg::NODE_W_DEF,
    parameter int OWN_W  = tidm_pkg::OWN_W_DEF
) (
    input  logic              clk,
    input  logic              commit,
    input  logic              commit_owner,
    input  logic [SLOT_W-1:0] commit_addr,
    input  logic [NODE_W-1:0] commit_data,
    input  logic [SLOT_W-1:0] node_addr,
    output logic [NODE_W-1:0] node_data,
    input  logic [SLOT_W-1:0] own_addr,
    output logic [OWN_W-1:0]  own_data
);
    localparam int SLOTS = 1 << SLOT_W;

    logic [NODE_W-1:0] node_mem [NODES];
    logic [OWN_W-1:0]  own_mem  [SLOTS];

    always_ff @(posedge clk) begin
        if (commit && !commit_owner && (int'(commit_addr) < NODES))
            node_mem[commit_addr] <= commit_data;
        if (commit && commit_owner)
            own_mem[commit_addr] <= commit_data[OWN_W-1:0];
    end

    assign node_data = (int'(node_addr) < NODES) ? node_mem[node_addr] : '0;
    assign own_data  = own_mem[own_addr];
endmodule

// File: rtl/tidm_wr_hold.sv
module tidm_wr_hold #(
    parameter int SLOT_W = tidm_pkg::SLOT_W_DEF,
    parameter int NODE_W = tidm_pkg::NODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_is_owner,
    input  logic [SLOT_W-1:0] wr_addr,
    input  logic [NODE_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              walk_busy,
    output logic              commit,
    output logic              commit_owner,
    output logic [SLOT_W-1:0] commit_addr,
    output logic [NODE_W-1:0] commit_data
);
    typedef struct packed {
        logic              valid;
        logic              owner;
        logic [SLOT_W-1:0] addr;
        logic [NODE_W-1:0] data;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (h_q.valid && !walk_busy)
            h_d.valid = 1'b0;
        if (wr_en && !h_q.valid) begin
            h_d.valid = 1'b1;
            h_d.owner = wr_is_owner;
            h_d.addr  = wr_addr;
            h_d.data  = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign wr_ready     = !h_q.valid;
    assign commit       = h_q.valid && !walk_busy;
    assign commit_owner = h_q.owner;
    assign commit_addr  = h_q.addr;
    assign commit_data  = h_q.data;
endmodule

// File: rtl/tidm_walker.sv
module tidm_walker
    import tidm_pkg::*;
#(
    parameter int KEY_W     = KEY_W_DEF,
    parameter int SLOT_W    = SLOT_W_DEF,
    parameter int NODES     = NODES_DEF,
    parameter int NODE_W    = NODE_W_DEF,
    parameter int MAX_DEPTH = MAX_DEPTH_DEF,
    parameter int OWN_W     = OWN_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [KEY_W-1:0]  req_key,
    output logic              req_ready,
    output logic [SLOT_W-1:0] node_addr,
    input  logic [NODE_W-1:0] node_data,
    output logic [SLOT_W-1:0] own_addr,
    input  logic [OWN_W-1:0]  own_data,
    input  logic [OWN_W-1:0]  cfg_owner,
    output logic              walk_busy,
    output logic              rsp_valid,
    output logic [SLOT_W:0]   rsp_slot,
    output logic              rsp_hit
);
    localparam int KEY_SPAN  = 1 << SEL_W;
    localparam int DEPTH_W   = $clog2(MAX_DEPTH);
    localparam int ONE_FLAG  = SLOT_W;
    localparam int ZERO_LO   = SLOT_W + 1;
    localparam int ZERO_FLAG = 2 * SLOT_W + 1;
    localparam int SEL_LO    = 2 * SLOT_W + 2;
    localparam int USED_W    = SEL_LO + SEL_W;
    localparam logic [SLOT_W:0] MISS = (SLOT_W+1)'(1 << SLOT_W);

    typedef struct packed {
        walk_state_e        st;
        logic [KEY_W-1:0]   key;
        logic [SLOT_W-1:0]  idx;
        logic [DEPTH_W-1:0] depth;
        logic               rsp_valid;
        logic [SLOT_W:0]    slot;
        logic               hit;
    } walk_t;

    walk_t w_d, w_q;

    logic [KEY_SPAN-1:0] key_ext;
    logic [SEL_W-1:0]    bit_sel;
    logic                tested;
    logic                cont;
    logic [SLOT_W-1:0]   res;
    logic                unused_hi;

    assign unused_hi = ^node_data[NODE_W-1:USED_W];

    always_comb begin
        key_ext              = '0;
        key_ext[KEY_W-1:0]   = w_q.key;
        bit_sel              = node_data[SEL_LO +: SEL_W];
        tested               = key_ext[bit_sel];
        cont                 = tested ? node_data[ONE_FLAG] : node_data[ZERO_FLAG];
        res                  = tested ? node_data[0 +: SLOT_W] : node_data[ZERO_LO +: SLOT_W];

        w_d           = w_q;
        w_d.rsp_valid = 1'b0;
        case (w_q.st)
            W_IDLE: begin
                if (req_valid) begin
                    w_d.st    = W_RUN;
                    w_d.key   = req_key;
                    w_d.idx   = '0;
                    w_d.depth = '0;
                end
            end
            default: begin
                if (!cont) begin
                    w_d.st        = W_IDLE;
                    w_d.rsp_valid = 1'b1;
                    if (own_data == cfg_owner) begin
                        w_d.slot = {1'b0, res};
                        w_d.hit  = 1'b1;
                    end else begin
                        w_d.slot = MISS;
                        w_d.hit  = 1'b0;
                    end
                end else if ((w_q.depth == DEPTH_W'(MAX_DEPTH - 1)) ||
                             (int'(res) >= NODES)) begin
                    w_d.st        = W_IDLE;
                    w_d.rsp_valid = 1'b1;
                    w_d.slot      = MISS;
                    w_d.hit       = 1'b0;
                end else begin
                    w_d.idx   = res;
                    w_d.depth = w_q.depth + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '{st: W_IDLE, default: '0};
        else        w_q <= w_d;
    end

    assign node_addr = w_q.idx;
    assign own_addr  = res;
    assign req_ready = (w_q.st == W_IDLE);
    assign walk_busy = (w_q.st != W_IDLE);
    assign rsp_valid = w_q.rsp_valid;
    assign rsp_slot  = w_q.slot;
    assign rsp_hit   = w_q.hit;
endmodule

// File: rtl/tree_id_mapper.sv
module tree_id_mapper #(
    parameter int KEY_W     = tidm_pkg::KEY_W_DEF,
    parameter int SLOT_W    = tidm_pkg::SLOT_W_DEF,
    parameter int NODES     = tidm_pkg::NODES_DEF,
    parameter int NODE_W    = tidm_pkg::NODE_W_DEF,
    parameter int MAX_DEPTH = tidm_pkg::MAX_DEPTH_DEF,
    parameter int OWN_W     = tidm_pkg::OWN_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [KEY_W-1:0]  req_key,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [SLOT_W:0]   rsp_slot,
    output logic              rsp_hit,
    input  logic [OWN_W-1:0]  cfg_owner,
    input  logic              wr_en,
    input  logic              wr_is_owner,
    input  logic [SLOT_W-1:0] wr_addr,
    input  logic [NODE_W-1:0] wr_data,
    output logic              wr_ready
);
    logic              walk_busy;
    logic              commit;
    logic              commit_owner;
    logic [SLOT_W-1:0] commit_addr;
    logic [NODE_W-1:0] commit_data;
    logic [SLOT_W-1:0] node_addr;
    logic [NODE_W-1:0] node_data;
    logic [SLOT_W-1:0] own_addr;
    logic [OWN_W-1:0]  own_data;

    tidm_wr_hold #(.SLOT_W(SLOT_W), .NODE_W(NODE_W)) i_hold (
        .clk, .rst_n, .wr_en, .wr_is_owner, .wr_addr, .wr_data, .wr_ready,
        .walk_busy, .commit, .commit_owner, .commit_addr, .commit_data
    );

    tidm_store #(.SLOT_W(SLOT_W), .NODES(NODES), .NODE_W(NODE_W), .OWN_W(OWN_W)) i_store (
        .clk, .commit, .commit_owner, .commit_addr, .commit_data,
        .node_addr, .node_data, .own_addr, .own_data
    );

    tidm_walker #(
        .KEY_W(KEY_W), .SLOT_W(SLOT_W), .NODES(NODES), .NODE_W(NODE_W),
        .MAX_DEPTH(MAX_DEPTH), .OWN_W(OWN_W)
    ) i_walker (
        .clk, .rst_n, .req_valid, .req_key, .req_ready, .node_addr, .node_data,
        .own_addr, .own_data, .cfg_owner, .walk_busy, .rsp_valid, .rsp_slot, .rsp_hit
    );
endmodule

// File: rtl/tidm_checker.sv
module tidm_checker #(
    parameter int SLOT_W    = 8,
    parameter int MAX_DEPTH = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic [SLOT_W:0] rsp_slot,
    input logic            rsp_hit,
    input logic            wr_ready
);
    localparam int CNT_W = $clog2(MAX_DEPTH + 2) + 1;
    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          busy_cnt <= '0;
        else if (req_ready)  busy_cnt <= '0;
        else                 busy_cnt <= busy_cnt + 1'b1;
    end

    assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_rsp_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!req_ready));
    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_walk_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(busy_cnt) <= MAX_DEPTH);
    assert_hit_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !rsp_slot[SLOT_W]);
    assert_miss_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_slot == (SLOT_W+1)'(1 << SLOT_W)));
    assert_write_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ready && req_ready) |=> wr_ready);
endmodule

bind tree_id_mapper tidm_checker #(.SLOT_W(SLOT_W), .MAX_DEPTH(MAX_DEPTH)) i_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_slot(rsp_slot), .rsp_hit(rsp_hit), .wr_ready(wr_ready)
);

// File: tb/test_tree_id_mapper.sv
`timescale 1ns/1ps
module test_tree_id_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_key = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [8:0]  rsp_slot;
    logic        rsp_hit;
    logic [2:0]  cfg_owner = 3'd3;
    logic        wr_en = 1'b0;
    logic        wr_is_owner = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tree_id_mapper i_tree_id_mapper (
        .clk, .rst_n, .req_valid, .req_key, .req_ready, .rsp_valid, .rsp_slot,
        .rsp_hit, .cfg_owner, .wr_en, .wr_is_owner, .wr_addr, .wr_data, .wr_ready
    );

    // Vectors: key, expected slot, expected hit, expected nodes visited
    localparam int NV = 7;
    localparam logic [11:0] V_KEY  [NV] = '{12'h000, 12'h001, 12'h7FF, 12'h800, 12'h820, 12'hFDF, 12'hFFE};
    localparam logic [8:0]  V_SLOT [NV] = '{9'd10, 9'd11, 9'd11, 9'd30, 9'd256, 9'd30, 9'd256};
    localparam logic        V_HIT  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam int          V_LEN  [NV] = '{2, 2, 2, 3, 2, 3, 2};

    function automatic logic [31:0] mk(int b, bit c0, int r0, bit c1, int r1);
        return {10'd0, 4'(b), c0, 8'(r0), c1, 8'(r1)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit own, input int addr, input logic [31:0] data);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_en = 1'b1; wr_is_owner = own; wr_addr = 8'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic walk(input logic [11:0] key, output logic [8:0] slot,
                        output logic hit, output int n);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_key = key;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0; slot = '0; hit = 1'b0;
        while (n < 40) begin
            @(negedge clk);
            n++;
            if (rsp_valid) begin
                slot = rsp_slot; hit = rsp_hit;
                break;
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [8:0] s;
        logic       h;
        int         n;
        int         cnt;
        int         extra;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 req_ready", 32'(req_ready), 1);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 wr_ready", 32'(wr_ready), 1);
        rst_n = 1'b1;

        // Tree: node0 bit11; node1 bit0; node2 bit5; node3 bit14 (above key)
        wr(0, 0, mk(11, 1, 1, 1, 2));
        wr(0, 1, mk(0, 0, 10, 0, 11));
        wr(0, 2, mk(5, 1, 3, 0, 20));
        wr(0, 3, mk(14, 0, 30, 0, 31));
        wr(1, 10, 32'd3);
        wr(1, 11, 32'd3);
        wr(1, 20, 32'd5);
        wr(1, 30, 32'd3);
        wr(1, 77, 32'd3);

        // R2 R3 R4 R5 R8 vector walk
        for (int i = 0; i < NV; i++) begin
            walk(V_KEY[i], s, h, n);
            chk("R3 R4 slot", 32'(s), 32'(V_SLOT[i]));
            chk("R8 hit", 32'(h), 32'(V_HIT[i]));
            chk("R5 latency", 32'(n), 32'(V_LEN[i]));
        end

        // R10: request held high while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_key = 12'h800;
        @(negedge clk);
        req_key = 12'h001;
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 1; s = '0;
        while (cnt < 10 && !rsp_valid) begin @(negedge clk); cnt++; end
        chk("R10 first slot", 32'(rsp_slot), 30);
        extra = 0;
        repeat (5) begin @(negedge clk); if (rsp_valid) extra++; end
        chk("R10 no extra response", 32'(extra), 0);

        // R7: pointer to index 255 ends as miss
        wr(0, 1, mk(0, 1, 255, 0, 11));
        walk(12'h000, s, h, n);
        chk("R7 slot", 32'(s), 256);
        chk("R7 hit", 32'(h), 0);
        chk("R7 latency", 32'(n), 2);
        walk(12'h001, s, h, n);
        chk("R3 one path intact", 32'(s), 11);

        // R6 and R9: self-looping node3, rewritten during the walk
        wr(0, 3, mk(14, 1, 3, 0, 31));
        @(negedge clk);
        req_valid = 1'b1; req_key = 12'h800;
        @(negedge clk);
        req_valid = 1'b0;
        wr_en = 1'b1; wr_is_owner = 1'b0; wr_addr = 8'd3; wr_data = mk(14, 0, 77, 0, 77);
        cnt = 0;
        while (cnt < 40) begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) begin
                wr_en = 1'b0;
                chk("R9 wr_ready low while parked", 32'(wr_ready), 0);
            end
            if (rsp_valid) break;
        end
        chk("R6 depth miss slot", 32'(rsp_slot), 256);
        chk("R6 depth miss hit", 32'(rsp_hit), 0);
        chk("R6 depth latency", 32'(cnt), 16);
        @(negedge clk);
        @(negedge clk);
        chk("R9 write drained", 32'(wr_ready), 1);
        walk(12'h800, s, h, n);
        chk("R9 write applied", 32'(s), 77);
        chk("R9 latency", 32'(n), 3);

        // R8: owner changed to match slot 20
        cfg_owner = 3'd5;
        walk(12'h820, s, h, n);
        chk("R8 owner match slot", 32'(s), 20);
        chk("R8 owner match hit", 32'(h), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule